// File: doc/BRIEF.md
# Ordered Failure-Pair Detector with Gap Window

This block watches two repairable alarm lines, a left input `a_i` and a right input `b_i`. It raises its output only when the left alarm appears first and the right alarm follows while the left one is still active. It is a four-state Moore machine: idle, left-seen, blocked and fired. Only the fired state drives the output high. The output is taken from a flop.

A compile-time mode turns the plain ordering check into a timed one:

- **Plain:** any gap between the two alarms is accepted.
- **Minimum-gap:** the gap must be at least `GAP_TICKS`.
- **Maximum-gap:** the gap must be at most `GAP_TICKS`.

The gap is the number of clock edges from the first edge that samples `a_i` high to the first edge that samples `b_i` high. A saturating tick counter measures it. Whenever both inputs are sampled low, the machine returns to idle, so that a later episode can be judged afresh.

Top module: `pand_window_detector`

## Requirements
- R1: `fired_o` is 1 only after this sequence: `a_i` was sampled high while `b_i` was low, then `b_i` was sampled high while `a_i` stayed high, and both have stayed high at every edge since.
- R2: If `b_i` is sampled high before `a_i`, or on the same edge on which `a_i` first appears, the detector blocks. While blocked, `fired_o` stays 0 whatever the inputs do, until both inputs are sampled low.
- R3: An edge that samples both inputs low returns the detector to idle, and `fired_o` is 0 after that edge.
- R4: If `a_i` drops before `b_i` arrives, the detector returns to idle and does not fire later on that episode. A `b_i` that then appears alone blocks.
- R5: In minimum-gap mode, a gap of `GAP_TICKS` or more fires and a gap of `GAP_TICKS-1` blocks.
- R6: In maximum-gap mode, a gap of `GAP_TICKS` or less fires and a gap of `GAP_TICKS+1` blocks.
- R7: In plain mode, a correctly ordered pair fires for any gap of 1 or more.
- R8: The gap counter saturates and never wraps. A gap much longer than `GAP_TICKS` fires in minimum-gap mode and is rejected in maximum-gap mode.
- R9: From the fired state, `fired_o` falls after the first edge that samples either input low. It does not fire again until both inputs have been low together.
- R10: `fired_o` is 0 during reset. The active-low reset clears it asynchronously. `fired_o` changes only at the clock edge that samples the inputs deciding it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one edge is one tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Left alarm; must come first |
| b_i | input | 1 | Right alarm; must follow `a_i` |
| fired_o | output | 1 | Registered detection flag |

## Verification
Every result of this block is registered. The output reflects the inputs sampled at the edge just taken, so it is due one edge after the inputs are driven. The bench drives the inputs on the falling edge and reads `fired_o` one nanosecond after the next rising edge. One table row is therefore exactly one decision of the state machine.

Gap boundaries are placed by counting edges from the first row that holds `a_i` high. A separate check reads the output before the deciding edge, to confirm that nothing changes early. The asynchronous clear is checked in the middle of a cycle.

// File: rtl/pand_pkg.sv
package pand_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN   = 2'd0,
    MODE_MIN_GAP = 2'd1,
    MODE_MAX_GAP = 2'd2
  } gap_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_BLOCKED = 2'd2,
    ST_FIRED   = 2'd3
  } pand_state_e;
endpackage

// File: rtl/pand_gap_counter.sv
module pand_gap_counter #(
  parameter int LIMIT = 5,
  parameter int CW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          inc_i,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] cnt_q;

  // load_i marks the first tick with a high, so the count starts at one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (load_i)                       cnt_q <= CW'(1);
    else if (inc_i && cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + CW'(1);
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pand_gap_qual.sv
module pand_gap_qual
  import pand_pkg::*;
#(
  parameter gap_mode_e MODE      = MODE_MIN_GAP,
  parameter int        GAP_TICKS = 4,
  parameter int        CW        = 3
) (
  input  logic [CW-1:0] count_i,
  output logic          ok_o
);
  generate
    if (MODE == MODE_MIN_GAP) begin : g_min
      assign ok_o = count_i >= CW'(GAP_TICKS);
    end else if (MODE == MODE_MAX_GAP) begin : g_max
      assign ok_o = count_i <= CW'(GAP_TICKS);
    end else begin : g_plain
      logic unused_count;
      assign unused_count = ^count_i;
      assign ok_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pand_fsm.sv
module pand_fsm
  import pand_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  input  logic gap_ok_i,
  output logic load_o,
  output logic inc_o,
  output logic fired_o
);
  pand_state_e state_q, state_d;
  logic        fired_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (a_i && !b_i) state_d = ST_ARMED;
        else if (b_i)    state_d = ST_BLOCKED;
      end
      ST_ARMED: begin
        if (!a_i)     state_d = b_i ? ST_BLOCKED : ST_IDLE;
        else if (b_i) state_d = gap_ok_i ? ST_FIRED : ST_BLOCKED;
      end
      ST_BLOCKED: begin
        if (!a_i && !b_i) state_d = ST_IDLE;
      end
      ST_FIRED: begin
        if (!a_i && !b_i)      state_d = ST_IDLE;
        else if (!(a_i && b_i)) state_d = ST_BLOCKED;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign load_o = (state_q == ST_IDLE)  && a_i && !b_i;
  assign inc_o  = (state_q == ST_ARMED) && a_i && !b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fired_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fired_q <= (state_d == ST_FIRED);
    end
  end

  assign fired_o = fired_q;
endmodule

// File: rtl/pand_window_detector.sv
module pand_window_detector
  import pand_pkg::*;
#(
  parameter gap_mode_e MODE      = MODE_MIN_GAP,
  parameter int        GAP_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic fired_o
);
  // one step past the threshold so that "more than T" stays visible
  localparam int LIMIT = GAP_TICKS + 1;
  localparam int CW    = $clog2(LIMIT + 1);

  logic          load, inc, gap_ok;
  logic [CW-1:0] gap_cnt;

  pand_gap_counter #(.LIMIT(LIMIT), .CW(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .inc_i   (inc),
    .count_o (gap_cnt)
  );

  pand_gap_qual #(.MODE(MODE), .GAP_TICKS(GAP_TICKS), .CW(CW)) u_qual (
    .count_i (gap_cnt),
    .ok_o    (gap_ok)
  );

  pand_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (a_i),
    .b_i      (b_i),
    .gap_ok_i (gap_ok),
    .load_o   (load),
    .inc_o    (inc),
    .fired_o  (fired_o)
  );
endmodule

// File: rtl/pand_window_checker.sv
module pand_window_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic a_i,
  input logic b_i,
  input logic fired_o
);
  AST_FIRE_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fired_o |-> ($past(a_i) && $past(b_i))); // R1

  AST_RISE_ORDERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fired_o) |-> ($past(a_i, 2) && !$past(b_i, 2))); // R2

  AST_SIMUL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i && b_i && !$past(a_i)) |=> !fired_o); // R2

  AST_BOTH_LOW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_i && !b_i) |=> !fired_o); // R3

  AST_DROP_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_o && !(a_i && b_i)) |=> !fired_o); // R9
endmodule

bind pand_window_detector pand_window_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .a_i     (a_i),
  .b_i     (b_i),
  .fired_o (fired_o)
);

// File: tb/tb_pand_window_detector.sv
module tb_pand_window_detector;
  import pand_pkg::*;

  localparam int T  = 4;
  localparam int NV = 50;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic a = 1'b0, b = 1'b0;
  logic fired_min, fired_plain, fired_max;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  pand_window_detector #(.MODE(MODE_MIN_GAP), .GAP_TICKS(T)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .fired_o(fired_min));
  pand_window_detector #(.MODE(MODE_PLAIN), .GAP_TICKS(T)) dut_plain (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .fired_o(fired_plain));
  pand_window_detector #(.MODE(MODE_MAX_GAP), .GAP_TICKS(T)) dut_max (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .fired_o(fired_max));

  // {a, b, expect_plain, expect_min, expect_max}; gap T = 4
  localparam logic [4:0] VEC [NV] = '{
    5'b00_000, 5'b10_000, 5'b10_000, 5'b11_101, 5'b11_101, 5'b10_000, 5'b00_000,
    5'b10_000, 5'b10_000, 5'b10_000, 5'b10_000, 5'b11_111, 5'b11_111, 5'b00_000,
    5'b10_000, 5'b10_000, 5'b10_000, 5'b10_000, 5'b10_000, 5'b11_110, 5'b01_000,
    5'b11_000, 5'b00_000,
    5'b01_000, 5'b11_000, 5'b00_000,
    5'b11_000, 5'b10_000, 5'b11_000, 5'b00_000,
    5'b10_000, 5'b00_000, 5'b01_000, 5'b00_000,
    5'b10_000, 5'b10_000, 5'b10_000, 5'b11_101, 5'b00_000,
    5'b10_000, 5'b10_000, 5'b10_000, 5'b10_000, 5'b10_000, 5'b10_000, 5'b10_000,
    5'b10_000, 5'b10_000, 5'b11_110, 5'b00_000
  };

  function automatic string vec_req(input int i);
    if (i < 7)       return "R1 R5 R6 R7 gap2";
    else if (i < 14) return "R5 R6 gap=T";
    else if (i < 23) return "R6 R9 gap=T+1";
    else if (i < 26) return "R2 b-first";
    else if (i < 30) return "R2 same-tick";
    else if (i < 34) return "R4 R3 a-drops";
    else if (i < 39) return "R5 gap=T-1";
    else             return "R8 long-gap";
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic na, input logic nb);
    @(negedge clk);
    a = na;
    b = nb;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #10;
    chk(fired_min, 1'b0, "R10", "reset min");
    chk(fired_plain, 1'b0, "R10", "reset plain");
    chk(fired_max, 1'b0, "R10", "reset max");
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3]);
      chk(fired_plain, VEC[i][2], vec_req(i), $sformatf("plain row %0d", i));
      chk(fired_min,   VEC[i][1], vec_req(i), $sformatf("min row %0d", i));
      chk(fired_max,   VEC[i][0], vec_req(i), $sformatf("max row %0d", i));
    end

    // R10: no change before the deciding edge
    step(1'b1, 1'b0);
    @(negedge clk);
    a = 1'b1;
    b = 1'b1;
    #1;
    chk(fired_plain, 1'b0, "R10", "before edge");
    @(posedge clk);
    #1;
    chk(fired_plain, 1'b1, "R10", "after edge");

    // R10: asynchronous clear in mid-cycle
    #1;
    rst_ni = 1'b0;
    #0.5;
    chk(fired_plain, 1'b0, "R10", "async clear plain");
    chk(fired_max, 1'b0, "R10", "async clear max");
    @(negedge clk);
    a = 1'b0;
    b = 1'b0;
    rst_ni = 1'b1;

    // R3: fresh episode after reset, gap 1
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk(fired_plain, 1'b1, "R3 R7", "gap1 plain");
    chk(fired_max, 1'b1, "R3 R6", "gap1 max");
    chk(fired_min, 1'b0, "R5", "gap1 min");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule